// File: doc/BRIEF.md
# Interlocked Single-Word I/O Buffer

This block places a one-word holding register between a fast processor and a slow peripheral that runs on its own timing. The processor side deposits or collects words at full clock rate. The peripheral side acts only on a periodic sample strobe. The word-present flag serves as the interlock between the two sides. While it is set, the processor owns nothing further and must idle. While it is clear, the peripheral has nothing to take. Two independent channels are built side by side, so two devices can run at the same time.

A channel is brought into use by writing a select code word rather than data. The code word names one of eight devices, fixes the transfer direction and pulses a start signal. After that, data moves under the interlock rules. In output direction, the processor deposits words and the peripheral strobe takes them. A strobe that finds the buffer empty raises an underrun alarm. In input direction, the peripheral strobe loads words and the processor reads them. A strobe that finds the previous word still unread raises an overrun alarm and leaves that word in place. Alarms hold until a per-channel clear input is pulsed. A stop code deselects the device and empties the buffer.

Top module: `iobuf_pair`

## Requirements
- R1: While reset is asserted and right after its release, every channel shows an empty buffer, no active device, no start pulse and both alarms clear.
- R2: A write with `cpu_code` high is a select code word. Bits [2:0] of the data give the device ID, bit 3 set selects input direction, and bit 4 set means stop. A code write without stop activates the channel, sets `dev_id` and `dev_dir_in` from its fields, and raises `dev_start` for exactly the one cycle after the write. A code write also empties the buffer, even when it is full.
- R3: In output direction, a data write to an empty buffer is stored and sets `buf_full` from the next cycle on. A data write while `buf_full` is set drives `cpu_stall` high in that cycle and leaves the held word unchanged.
- R4: In output direction, a strobe while `buf_full` is set raises `dev_take` in the same cycle with the held word on `dev_rdata`, and the buffer is empty from the next cycle on. Words leave in the order they were deposited.
- R5: In output direction, a strobe on an empty buffer sets `alarm_empty` from the next cycle on. The alarm stays set until a cycle with `alarm_clr` high, after which it reads low.
- R6: In input direction, a strobe on an empty buffer loads `dev_wdata` and sets `buf_full`. A read while the buffer holds a word returns it on `cpu_rdata` in the same cycle and empties the buffer. A read on an empty buffer drives `cpu_stall` high.
- R7: In input direction, a strobe while the buffer is full sets the sticky `alarm_ovr` and does not overwrite the held word. The earlier word is still the one read back.
- R8: After a stop code, the channel is inactive and its buffer is empty. A strobe or data write on an inactive channel changes neither `buf_full` nor any alarm, and it causes no `dev_take`.
- R9: The channels are independent. A code word, transfer or alarm on one channel leaves the other channel's device ID, direction, buffer and alarms untouched, and both may transfer in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | NCH | Processor write request per channel |
| cpu_code | input | NCH | Marks the write as a select code word |
| cpu_wdata | input | NCH*W | Processor write data per channel |
| cpu_rd | input | NCH | Processor read request per channel |
| cpu_rdata | output | NCH*W | Word held by each channel, for reads |
| cpu_stall | output | NCH | Processor must idle and retry |
| dev_stb | input | NCH | Peripheral sample strobe per channel |
| dev_wdata | input | NCH*W | Peripheral data for input direction |
| dev_rdata | output | NCH*W | Word offered to the peripheral |
| dev_take | output | NCH | Peripheral took a word this cycle |
| dev_start | output | NCH | One-cycle start pulse after selection |
| dev_id | output | NCH*3 | Selected device ID per channel |
| dev_active | output | NCH | A device is selected |
| dev_dir_in | output | NCH | Selected direction is input |
| buf_full | output | NCH | Buffer holds a word (interlock state) |
| alarm_clr | input | NCH | Clears both alarms of a channel |
| alarm_empty | output | NCH | Sticky: strobe found output buffer empty |
| alarm_ovr | output | NCH | Sticky: strobe found input buffer full |

## Verification
The output path is driven with deposits into an empty buffer, deposits held against a full buffer across several stall cycles, and strobes on both a full and an empty buffer. Together these separate correct interlock behaviour from a buffer that overwrites, takes stale words, or fails to alarm. The input path runs the mirror pattern, with a second strobe before the read, which shows whether an overrun keeps the first word or lets the second through. Stop codes followed by stray strobes and writes show that an idle channel is truly inert. A concurrent phase with one channel sending and the other receiving in the same cycles exposes any cross-channel coupling.

// File: rtl/iobuf_pkg.sv
package iobuf_pkg;
  localparam int ID_W = 3;

  typedef struct packed {
    logic            stop;
    logic            dir_in;
    logic [ID_W-1:0] id;
  } sel_code_t;

  localparam int CODE_W = $bits(sel_code_t);

  function automatic sel_code_t decode_code(input logic [CODE_W-1:0] raw);
    return sel_code_t'(raw);
  endfunction
endpackage

// File: rtl/iobuf_flag.sv
module iobuf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= 1'b0;
    else if (clr) q <= 1'b0;
    else if (set) q <= 1'b1;
  end
endmodule

// File: rtl/iobuf_chan.sv
module iobuf_chan
  import iobuf_pkg::*;
#(
  parameter int W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpu_wr,
  input  logic            cpu_code,
  input  logic [W-1:0]    cpu_wdata,
  input  logic            cpu_rd,
  output logic [W-1:0]    cpu_rdata,
  output logic            cpu_stall,
  input  logic            dev_stb,
  input  logic [W-1:0]    dev_wdata,
  output logic [W-1:0]    dev_rdata,
  output logic            dev_take,
  output logic            dev_start,
  output logic [ID_W-1:0] dev_id,
  output logic            dev_active,
  output logic            dev_dir_in,
  output logic            buf_full,
  input  logic            alarm_clr,
  output logic            alarm_empty,
  output logic            alarm_ovr
);
  logic            full_q, active_q, dir_q, start_q;
  logic [ID_W-1:0] id_q;
  logic [W-1:0]    data_q;
  sel_code_t       code_w;

  assign code_w = decode_code(cpu_wdata[CODE_W-1:0]);

  // named internal events
  logic out_mode, in_mode;
  logic ev_code, ev_deposit, ev_take, ev_underrun, ev_load, ev_overrun, ev_read;
  assign out_mode    = active_q & ~dir_q;
  assign in_mode     = active_q & dir_q;
  assign ev_code     = cpu_wr & cpu_code;
  assign ev_deposit  = out_mode & cpu_wr & ~cpu_code & ~full_q;
  assign ev_take     = out_mode & dev_stb & full_q;
  assign ev_underrun = out_mode & dev_stb & ~full_q;
  assign ev_load     = in_mode & dev_stb & ~full_q;
  assign ev_overrun  = in_mode & dev_stb & full_q;
  assign ev_read     = in_mode & cpu_rd & full_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q   <= 1'b0;
      active_q <= 1'b0;
      dir_q    <= 1'b0;
      start_q  <= 1'b0;
      id_q     <= '0;
      data_q   <= '0;
    end else if (ev_code) begin
      full_q   <= 1'b0;
      active_q <= ~code_w.stop;
      dir_q    <= code_w.dir_in;
      id_q     <= code_w.id;
      start_q  <= ~code_w.stop;
    end else begin
      start_q <= 1'b0;
      if (ev_deposit) begin
        data_q <= cpu_wdata;
        full_q <= 1'b1;
      end else if (ev_load) begin
        data_q <= dev_wdata;
        full_q <= 1'b1;
      end else if (ev_take || ev_read) begin
        full_q <= 1'b0;
      end
    end
  end

  iobuf_flag u_alm_empty (.clk(clk), .rst_n(rst_n), .set(ev_underrun),
                          .clr(alarm_clr), .q(alarm_empty));
  iobuf_flag u_alm_ovr   (.clk(clk), .rst_n(rst_n), .set(ev_overrun),
                          .clr(alarm_clr), .q(alarm_ovr));

  assign cpu_stall  = (out_mode & cpu_wr & ~cpu_code & full_q) |
                      (in_mode & cpu_rd & ~full_q);
  assign cpu_rdata  = data_q;
  assign dev_rdata  = data_q;
  assign dev_take   = ev_take;
  assign dev_start  = start_q;
  assign dev_id     = id_q;
  assign dev_active = active_q;
  assign dev_dir_in = dir_q;
  assign buf_full   = full_q;
endmodule

// File: rtl/iobuf_pair.sv
module iobuf_pair
  import iobuf_pkg::*;
#(
  parameter int NCH = 2,
  parameter int W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCH-1:0]     cpu_wr,
  input  logic [NCH-1:0]     cpu_code,
  input  logic [NCH*W-1:0]   cpu_wdata,
  input  logic [NCH-1:0]     cpu_rd,
  output logic [NCH*W-1:0]   cpu_rdata,
  output logic [NCH-1:0]     cpu_stall,
  input  logic [NCH-1:0]     dev_stb,
  input  logic [NCH*W-1:0]   dev_wdata,
  output logic [NCH*W-1:0]   dev_rdata,
  output logic [NCH-1:0]     dev_take,
  output logic [NCH-1:0]     dev_start,
  output logic [NCH*ID_W-1:0] dev_id,
  output logic [NCH-1:0]     dev_active,
  output logic [NCH-1:0]     dev_dir_in,
  output logic [NCH-1:0]     buf_full,
  input  logic [NCH-1:0]     alarm_clr,
  output logic [NCH-1:0]     alarm_empty,
  output logic [NCH-1:0]     alarm_ovr
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    iobuf_chan #(.W(W)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .cpu_wr     (cpu_wr[g]),
      .cpu_code   (cpu_code[g]),
      .cpu_wdata  (cpu_wdata[g*W +: W]),
      .cpu_rd     (cpu_rd[g]),
      .cpu_rdata  (cpu_rdata[g*W +: W]),
      .cpu_stall  (cpu_stall[g]),
      .dev_stb    (dev_stb[g]),
      .dev_wdata  (dev_wdata[g*W +: W]),
      .dev_rdata  (dev_rdata[g*W +: W]),
      .dev_take   (dev_take[g]),
      .dev_start  (dev_start[g]),
      .dev_id     (dev_id[g*ID_W +: ID_W]),
      .dev_active (dev_active[g]),
      .dev_dir_in (dev_dir_in[g]),
      .buf_full   (buf_full[g]),
      .alarm_clr  (alarm_clr[g]),
      .alarm_empty(alarm_empty[g]),
      .alarm_ovr  (alarm_ovr[g])
    );
  end
endmodule

// File: rtl/iobuf_pair_chk.sv
module iobuf_pair_chk
  import iobuf_pkg::*;
#(
  parameter int NCH = 2,
  parameter int W   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NCH-1:0]     cpu_wr,
  input logic [NCH-1:0]     cpu_code,
  input logic [NCH*W-1:0]   cpu_wdata,
  input logic [NCH-1:0]     cpu_rd,
  input logic [NCH*W-1:0]   cpu_rdata,
  input logic [NCH-1:0]     cpu_stall,
  input logic [NCH-1:0]     dev_stb,
  input logic [NCH*W-1:0]   dev_wdata,
  input logic [NCH*W-1:0]   dev_rdata,
  input logic [NCH-1:0]     dev_take,
  input logic [NCH-1:0]     dev_start,
  input logic [NCH*ID_W-1:0] dev_id,
  input logic [NCH-1:0]     dev_active,
  input logic [NCH-1:0]     dev_dir_in,
  input logic [NCH-1:0]     buf_full,
  input logic [NCH-1:0]     alarm_clr,
  input logic [NCH-1:0]     alarm_empty,
  input logic [NCH-1:0]     alarm_ovr
);
  for (genvar g = 0; g < NCH; g++) begin : g_chk
    a_r2_start_after_code: assert property (@(posedge clk) disable iff (!rst_n)
      dev_start[g] |-> $past(cpu_wr[g] & cpu_code[g] & ~cpu_wdata[g*W + 4]));

    a_r4_take_empties: assert property (@(posedge clk) disable iff (!rst_n)
      dev_take[g] |=> !buf_full[g]);

    a_r3_held_word_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_full[g] && !(cpu_wr[g] && cpu_code[g])) |=> $stable(dev_rdata[g*W +: W]));

    a_r5_empty_alarm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_empty[g] && !alarm_clr[g]) |=> alarm_empty[g]);

    a_r7_ovr_alarm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_ovr[g] && !alarm_clr[g]) |=> alarm_ovr[g]);
  end
endmodule

bind iobuf_pair iobuf_pair_chk #(.NCH(NCH), .W(W)) u_chk (.*);

// File: tb/iobuf_pair_bench.sv
module iobuf_pair_bench;
  localparam int NCH = 2;
  localparam int W   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0]   cpu_wr = '0, cpu_code = '0, cpu_rd = '0, dev_stb = '0, alarm_clr = '0;
  logic [NCH*W-1:0] cpu_wdata = '0, dev_wdata = '0;
  logic [NCH*W-1:0] cpu_rdata, dev_rdata;
  logic [NCH-1:0]   cpu_stall, dev_take, dev_start, dev_active, dev_dir_in, buf_full;
  logic [NCH-1:0]   alarm_empty, alarm_ovr;
  logic [NCH*3-1:0] dev_id;

  int n_chk = 0, n_fail = 0;
  logic [W-1:0] qo0[$], qo1[$], qi0[$], qi1[$];

  always #4 clk = ~clk;

  iobuf_pair #(.NCH(NCH), .W(W)) u_iobuf_pair (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sb_cmp(input string req, input logic [W-1:0] act, input int have,
                        input logic [W-1:0] exp);
    n_chk++;
    if (have == 0) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected no transfer", req, act);
    end else if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: compares words leaving the buffer against the scoreboard queues
  always @(negedge clk) if (rst_n) begin
    logic [W-1:0] e;
    if (dev_take[0]) begin e = (qo0.size() != 0) ? qo0[0] : '0;
      sb_cmp("R4 ch0 take", dev_rdata[W-1:0], qo0.size(), e); if (qo0.size() != 0) void'(qo0.pop_front()); end
    if (dev_take[1]) begin e = (qo1.size() != 0) ? qo1[0] : '0;
      sb_cmp("R4 ch1 take", dev_rdata[2*W-1:W], qo1.size(), e); if (qo1.size() != 0) void'(qo1.pop_front()); end
    if (cpu_rd[0] && !cpu_stall[0] && dev_active[0] && dev_dir_in[0]) begin e = (qi0.size() != 0) ? qi0[0] : '0;
      sb_cmp("R6 ch0 read", cpu_rdata[W-1:0], qi0.size(), e); if (qi0.size() != 0) void'(qi0.pop_front()); end
    if (cpu_rd[1] && !cpu_stall[1] && dev_active[1] && dev_dir_in[1]) begin e = (qi1.size() != 0) ? qi1[0] : '0;
      sb_cmp("R6 ch1 read", cpu_rdata[2*W-1:W], qi1.size(), e); if (qi1.size() != 0) void'(qi1.pop_front()); end
  end

  task automatic step(); @(posedge clk); #1; endtask

  task automatic code_wr(input int ch, input logic [2:0] id, input logic din, input logic stp);
    step(); cpu_wr[ch] = 1; cpu_code[ch] = 1; cpu_wdata[ch*W +: W] = W'({stp, din, id});
    step(); cpu_wr[ch] = 0; cpu_code[ch] = 0;
  endtask

  task automatic dep(input int ch, input logic [W-1:0] d, input bit push);
    step(); cpu_wr[ch] = 1; cpu_wdata[ch*W +: W] = d;
    if (push) begin if (ch == 0) qo0.push_back(d); else qo1.push_back(d); end
    step(); cpu_wr[ch] = 0;
  endtask

  task automatic strobe(input int ch, input logic [W-1:0] d, input bit push);
    step(); dev_stb[ch] = 1; dev_wdata[ch*W +: W] = d;
    if (push) begin if (ch == 0) qi0.push_back(d); else qi1.push_back(d); end
    step(); dev_stb[ch] = 0;
  endtask

  task automatic clr_alarm(input int ch);
    step(); alarm_clr[ch] = 1; step(); alarm_clr[ch] = 0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) step();
    #2;
    check("R1 full in reset", buf_full, 0);
    check("R1 active in reset", dev_active, 0);
    check("R1 alarms in reset", {alarm_empty, alarm_ovr}, 0);
    step(); rst_n = 1; step(); #2;
    check("R1 start after reset", dev_start, 0);
    check("R1 full after reset", buf_full, 0);

    // R2: select device 5, output direction on channel 0
    code_wr(0, 3'd5, 1'b0, 1'b0); #2;
    check("R2 start pulse", dev_start[0], 1);
    check("R2 device id", dev_id[2:0], 5);
    check("R2 active", dev_active[0], 1);
    check("R2 direction out", dev_dir_in[0], 0);
    step(); #2;
    check("R2 start one cycle", dev_start[0], 0);

    // R3: deposit then stall against a full buffer
    dep(0, 16'hA1A1, 1); #2;
    check("R3 full after deposit", buf_full[0], 1);
    step(); cpu_wr[0] = 1; cpu_wdata[W-1:0] = 16'hB2B2; #2;
    check("R3 stall when full", cpu_stall[0], 1);
    step(); #2;
    check("R3 stall held", cpu_stall[0], 1);
    check("R3 word unchanged", dev_rdata[W-1:0], 16'hA1A1);
    cpu_wr[0] = 0;

    // R4: strobe takes held word, then buffer empty
    strobe(0, '0, 0); #2;
    check("R4 empty after take", buf_full[0], 0);
    dep(0, 16'hB2B2, 1);
    strobe(0, '0, 0); #2;
    check("R4 empty after second take", buf_full[0], 0);

    // R5: strobe on empty buffer raises sticky alarm
    strobe(0, '0, 0); #2;
    check("R5 underrun alarm", alarm_empty[0], 1);
    repeat (3) step(); #2;
    check("R5 alarm sticky", alarm_empty[0], 1);
    clr_alarm(0); #2;
    check("R5 alarm cleared", alarm_empty[0], 0);

    // R8: stop code empties the buffer; idle channel is inert
    dep(0, 16'hC3C3, 0); #2;
    check("R8 full before stop", buf_full[0], 1);
    code_wr(0, 3'd0, 1'b0, 1'b1); #2;
    check("R8 inactive after stop", dev_active[0], 0);
    check("R8 no start on stop", dev_start[0], 0);
    check("R8 empty after stop", buf_full[0], 0);
    strobe(0, '0, 0); #2;
    check("R8 strobe ignored", {alarm_empty[0], alarm_ovr[0]}, 0);
    dep(0, 16'hD4D4, 0); #2;
    check("R8 write ignored", buf_full[0], 0);

    // R6/R7: channel 1 input direction, device 2
    code_wr(1, 3'd2, 1'b1, 1'b0); #2;
    check("R2 ch1 direction in", dev_dir_in[1], 1);
    check("R2 ch1 id", dev_id[5:3], 2);
    step(); cpu_rd[1] = 1; #2;
    check("R6 read stalls when empty", cpu_stall[1], 1);
    step(); cpu_rd[1] = 0;
    strobe(1, 16'h1111, 1); #2;
    check("R6 full after load", buf_full[1], 1);
    strobe(1, 16'h2222, 0); #2;
    check("R7 overrun alarm", alarm_ovr[1], 1);
    check("R7 first word kept", cpu_rdata[2*W-1:W], 16'h1111);
    step(); cpu_rd[1] = 1; #2;
    check("R6 no stall when full", cpu_stall[1], 0);
    step(); cpu_rd[1] = 0; #2;
    check("R6 empty after read", buf_full[1], 0);
    check("R7 alarm still set", alarm_ovr[1], 1);
    clr_alarm(1); #2;
    check("R7 alarm cleared", alarm_ovr[1], 0);

    // R9: both channels in the same cycles
    code_wr(0, 3'd3, 1'b0, 1'b0); #2;
    check("R9 ch0 id", dev_id[2:0], 3);
    check("R9 ch1 id untouched", dev_id[5:3], 2);
    check("R9 ch1 dir untouched", dev_dir_in[1], 1);
    step();
    cpu_wr[0] = 1; cpu_wdata[W-1:0] = 16'h5A5A; qo0.push_back(16'h5A5A);
    dev_stb[1] = 1; dev_wdata[2*W-1:W] = 16'h6B6B; qi1.push_back(16'h6B6B);
    step(); cpu_wr[0] = 0; dev_stb[1] = 0; #2;
    check("R9 both full", buf_full, 2'b11);
    step(); dev_stb[0] = 1; cpu_rd[1] = 1;
    step(); dev_stb[0] = 0; cpu_rd[1] = 0; #2;
    check("R9 both empty", buf_full, 2'b00);
    check("R9 no alarms", {alarm_empty, alarm_ovr}, 0);

    step(); #2;
    check("R4 output queues drained", qo0.size() + qo1.size(), 0);
    check("R6 input queues drained", qi0.size() + qi1.size(), 0);
    summary();
  end
endmodule